// File: doc/BRIEF.md
# Vector Register Branch Condition Unit

This unit resolves the condition of a conditional branch that tests a 128-bit vector register. The caller supplies the low 23 bits of the instruction word, the value of the vector register named there, the program counter of the branch, a pre-decoded branch family and two mode flags. One cycle after an accepted request the unit reports a registered result: the taken flag, the branch target, the index of the tested register and a reserved-instruction exception flag.

Two of the branch families look at the vector as a whole: one is taken when every bit is clear, the other when any bit is set. The other two look at lanes of 8, 16, 32 or 64 bits, with the width chosen by a 2-bit format field. One is taken when at least one lane is zero, the other when no lane is zero. Every lane of every 64-bit half is tested at once with a borrow trick: subtract a constant holding a one in each lane's lowest bit, keep only bits where the operand was clear, and look at the lane top bits. The caller's bits above bit 22 carry the major opcode, which it has already decoded into the family select.

When the newer-release mode is on and the branch sits in a delay or forbidden slot, the unit raises the exception and reports the branch as not taken.

Top module: `vbc_top`

## Requirements
- R1: One clock edge after a cycle with `inValid` high, `outValid` is high, and `taken`, `target`, `regIdx` and `resvExc` all reflect that request; after a cycle with `inValid` low, `outValid` is low.
- R2: `target` equals `pc + 4 + (sign-extended insnField[15:0] << 2)`, wrapped to 32 bits.
- R3: With `familySel` = 0 (whole-vector zero), `taken` is 1 exactly when all 128 bits of `vecData` are 0.
- R4: With `familySel` = 1 (whole-vector non-zero), `taken` is 1 exactly when at least one bit of `vecData` is 1.
- R5: With `familySel` = 2 (some lane zero), `taken` is 1 exactly when at least one lane is all zero; the lane width is taken from `insnField[22:21]`: 0 = 8 bits, 1 = 16, 2 = 32, 3 = 64, lanes aligned from bit 0.
- R6: With `familySel` = 3 (every lane non-zero), `taken` is 1 exactly when no lane is all zero, with the lane width encoded as in R5.
- R7: When `rel6Mode` and `slotFlag` are both 1 on an accepted request, `resvExc` is 1 and `taken` is 0, whatever the vector holds.
- R8: When either `rel6Mode` or `slotFlag` is 0 on an accepted request, `resvExc` is 0.
- R9: After reset and before any request, `outValid`, `taken` and `resvExc` are 0.
- R10: For `familySel` 0 and 1 the format field `insnField[22:21]` has no effect on `taken`.
- R11: `regIdx` equals `insnField[20:16]` of the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | A branch request is present this cycle |
| insnField | input | 23 | Instruction bits 22:0 (format, register index, offset) |
| familySel | input | 2 | Branch family: 0 all-zero, 1 any-set, 2 some lane zero, 3 no lane zero |
| vecData | input | 128 | Value of the tested vector register |
| pc | input | 32 | Address of the branch |
| rel6Mode | input | 1 | Newer-release rules are in force |
| slotFlag | input | 1 | The branch sits in a delay or forbidden slot |
| outValid | output | 1 | Result registers hold a fresh result |
| taken | output | 1 | Branch condition holds |
| target | output | 32 | Branch target address |
| regIdx | output | 5 | Index of the tested vector register |
| resvExc | output | 1 | Reserved-instruction exception |

## Verification
The exception check and the condition evaluation land in the same cycle: a branch whose vector would make it taken can also arrive in a slot with the newer-release mode on. The bench provokes this by sending, for every family, a vector known to satisfy that family's condition with both flags set, and judges that `resvExc` is 1 while `taken` is 0 and `target` still carries the computed address. It then repeats with only one of the two flags set and expects the condition to pass through with no exception.

// File: rtl/vbc_pkg.sv
package vbc_pkg;

  // Branch family encoding driven by the caller's opcode decode
  typedef enum logic [1:0] {
    FAM_ALL_ZERO   = 2'd0,
    FAM_ANY_SET    = 2'd1,
    FAM_LANE_ZERO  = 2'd2,
    FAM_NO_LANE_ZERO = 2'd3
  } vbcFamily_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic       capture;   // load result registers
    logic       useWhole;  // whole-vector test instead of lane test
    logic       invert;    // invert the zero-style condition
    logic       raiseExc;  // reserved-instruction exception
    logic [1:0] laneFmt;   // lane width code, 8 << code bits
  } vbcStrobes_t;

endpackage

// File: rtl/vbc_ctrl.sv
module vbc_ctrl
  import vbc_pkg::*;
#(
  parameter int FMT_LSB = 21
) (
  input  logic              inValid,
  input  logic [1:0]        familySel,
  input  logic [FMT_LSB+1:FMT_LSB] fmtField,
  input  logic              rel6Mode,
  input  logic              slotFlag,
  output vbcStrobes_t       strobes
);

  vbcFamily_e family;

  always_comb begin
    family           = vbcFamily_e'(familySel);
    strobes.capture  = inValid;
    strobes.raiseExc = rel6Mode & slotFlag;
    strobes.laneFmt  = fmtField;
    unique case (family)
      FAM_ALL_ZERO:     begin strobes.useWhole = 1'b1; strobes.invert = 1'b0; end
      FAM_ANY_SET:      begin strobes.useWhole = 1'b1; strobes.invert = 1'b1; end
      FAM_LANE_ZERO:    begin strobes.useWhole = 1'b0; strobes.invert = 1'b0; end
      FAM_NO_LANE_ZERO: begin strobes.useWhole = 1'b0; strobes.invert = 1'b1; end
      default:          begin strobes.useWhole = 1'b1; strobes.invert = 1'b0; end
    endcase
  end

endmodule

// File: rtl/vbc_lane_zero.sv
module vbc_lane_zero #(
  parameter int VEC_W  = 128,
  parameter int HALF_W = 64
) (
  input  logic [VEC_W-1:0] vecData,
  input  logic [1:0]       laneFmt,
  output logic             anyLaneZero,
  output logic             allBitsZero
);

  localparam int NUM_HALVES = VEC_W / HALF_W;

  logic [HALF_W-1:0] onesK;
  logic [HALF_W-1:0] msbK;
  logic [NUM_HALVES-1:0] halfHit;

  // Per-lane constants: one in each lane's bit 0, one in each lane's top bit
  always_comb begin
    int laneW;
    laneW = 8 << laneFmt;
    for (int b = 0; b < HALF_W; b++) begin
      onesK[b] = ((b % laneW) == 0);
      msbK[b]  = ((b % laneW) == (laneW - 1));
    end
  end

  generate
    for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
      logic [HALF_W-1:0] halfVal;
      logic [HALF_W-1:0] borrowed;
      assign halfVal    = vecData[h*HALF_W +: HALF_W];
      assign borrowed   = halfVal - onesK;
      assign halfHit[h] = |(borrowed & ~halfVal & msbK);
    end
  endgenerate

  assign anyLaneZero = |halfHit;
  assign allBitsZero = ~|vecData;

endmodule

// File: rtl/vbc_datapath.sv
module vbc_datapath
  import vbc_pkg::*;
#(
  parameter int VEC_W  = 128,
  parameter int HALF_W = 64,
  parameter int PC_W   = 32,
  parameter int OFF_W  = 16,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  vbcStrobes_t       strobes,
  input  logic [VEC_W-1:0]  vecData,
  input  logic [PC_W-1:0]   pc,
  input  logic [OFF_W-1:0]  offset,
  input  logic [IDX_W-1:0]  idxIn,
  output logic              outValid,
  output logic              taken,
  output logic [PC_W-1:0]   target,
  output logic [IDX_W-1:0]  regIdx,
  output logic              resvExc
);

  localparam int EXT_W = PC_W - OFF_W - 2;

  logic anyLaneZero;
  logic allBitsZero;
  logic zeroStyle;
  logic condNext;
  logic [PC_W-1:0] targetNext;

  vbc_lane_zero #(.VEC_W(VEC_W), .HALF_W(HALF_W)) u_zero (
    .vecData     (vecData),
    .laneFmt     (strobes.laneFmt),
    .anyLaneZero (anyLaneZero),
    .allBitsZero (allBitsZero)
  );

  always_comb begin
    zeroStyle  = strobes.useWhole ? allBitsZero : anyLaneZero;
    condNext   = (zeroStyle ^ strobes.invert) & ~strobes.raiseExc;
    targetNext = pc + PC_W'(4) + {{EXT_W{offset[OFF_W-1]}}, offset, 2'b00};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      taken    <= 1'b0;
      resvExc  <= 1'b0;
      target   <= '0;
      regIdx   <= '0;
    end else begin
      outValid <= strobes.capture;
      if (strobes.capture) begin
        taken   <= condNext;
        resvExc <= strobes.raiseExc;
        target  <= targetNext;
        regIdx  <= idxIn;
      end
    end
  end

endmodule

// File: rtl/vbc_top.sv
module vbc_top
  import vbc_pkg::*;
#(
  parameter int VEC_W  = 128,
  parameter int HALF_W = 64,
  parameter int PC_W   = 32,
  parameter int INSN_W = 23
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [INSN_W-1:0] insnField,
  input  logic [1:0]        familySel,
  input  logic [VEC_W-1:0]  vecData,
  input  logic [PC_W-1:0]   pc,
  input  logic              rel6Mode,
  input  logic              slotFlag,
  output logic              outValid,
  output logic              taken,
  output logic [PC_W-1:0]   target,
  output logic [4:0]        regIdx,
  output logic              resvExc
);

  localparam int FMT_LSB = 21;
  localparam int IDX_LSB = 16;
  localparam int IDX_W   = 5;
  localparam int OFF_W   = 16;

  vbcStrobes_t strobes;

  vbc_ctrl #(.FMT_LSB(FMT_LSB)) u_ctrl (
    .inValid   (inValid),
    .familySel (familySel),
    .fmtField  (insnField[FMT_LSB+1:FMT_LSB]),
    .rel6Mode  (rel6Mode),
    .slotFlag  (slotFlag),
    .strobes   (strobes)
  );

  vbc_datapath #(
    .VEC_W(VEC_W), .HALF_W(HALF_W), .PC_W(PC_W), .OFF_W(OFF_W), .IDX_W(IDX_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .vecData  (vecData),
    .pc       (pc),
    .offset   (insnField[OFF_W-1:0]),
    .idxIn    (insnField[IDX_LSB+IDX_W-1:IDX_LSB]),
    .outValid (outValid),
    .taken    (taken),
    .target   (target),
    .regIdx   (regIdx),
    .resvExc  (resvExc)
  );

endmodule

// File: rtl/vbc_checker.sv
module vbc_checker #(
  parameter int VEC_W  = 128,
  parameter int PC_W   = 32,
  parameter int INSN_W = 23
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [INSN_W-1:0] insnField,
  input logic [1:0]        familySel,
  input logic [VEC_W-1:0]  vecData,
  input logic [PC_W-1:0]   pc,
  input logic              rel6Mode,
  input logic              slotFlag,
  input logic              outValid,
  input logic              taken,
  input logic [PC_W-1:0]   target,
  input logic [4:0]        regIdx,
  input logic              resvExc
);

  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  a_r1_idle_follows: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
  a_r2_target: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> target == $past(pc) + 32'd4 +
      {{14{$past(insnField[15])}}, $past(insnField[15:0]), 2'b00});
  a_r3_all_zero: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && familySel == 2'd0 && !(rel6Mode && slotFlag)) |=>
      taken == ($past(vecData) == '0));
  a_r4_any_set: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && familySel == 2'd1 && !(rel6Mode && slotFlag)) |=>
      taken == ($past(vecData) != '0));
  a_r7_exc_raised: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && rel6Mode && slotFlag) |=> (resvExc && !taken));
  a_r8_no_exc: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !(rel6Mode && slotFlag)) |=> !resvExc);
  a_r11_index: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> regIdx == $past(insnField[20:16]));

endmodule

bind vbc_top vbc_checker #(.VEC_W(VEC_W), .PC_W(PC_W), .INSN_W(INSN_W)) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .insnField(insnField),
  .familySel(familySel), .vecData(vecData), .pc(pc), .rel6Mode(rel6Mode),
  .slotFlag(slotFlag), .outValid(outValid), .taken(taken), .target(target),
  .regIdx(regIdx), .resvExc(resvExc)
);

// File: tb/vbc_top_tb.sv
module vbc_top_tb;

  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rstN;
  logic         inValid;
  logic [22:0]  insnField;
  logic [1:0]   familySel;
  logic [127:0] vecData;
  logic [31:0]  pc;
  logic         rel6Mode;
  logic         slotFlag;
  logic         outValid;
  logic         taken;
  logic [31:0]  target;
  logic [4:0]   regIdx;
  logic         resvExc;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vbc_top u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .insnField(insnField),
    .familySel(familySel), .vecData(vecData), .pc(pc), .rel6Mode(rel6Mode),
    .slotFlag(slotFlag), .outValid(outValid), .taken(taken), .target(target),
    .regIdx(regIdx), .resvExc(resvExc)
  );

  // Reference: plain per-lane compare
  function automatic bit refLaneZero(logic [127:0] v, int fmt);
    int w;
    bit hit;
    w = 8 << fmt;
    hit = 1'b0;
    for (int l = 0; l < 128 / w; l++) begin
      bit z;
      z = 1'b1;
      for (int b = 0; b < w; b++) if (v[l*w + b]) z = 1'b0;
      if (z) hit = 1'b1;
    end
    return hit;
  endfunction

  function automatic bit refTaken(logic [127:0] v, int fam, int fmt, bit exc);
    bit c;
    case (fam)
      0: c = (v == '0);
      1: c = (v != '0);
      2: c = refLaneZero(v, fmt);
      default: c = !refLaneZero(v, fmt);
    endcase
    return exc ? 1'b0 : c;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // One request; result sampled on the following falling edge
  task automatic issue(string req, int fam, int fmt, logic [127:0] v,
                       logic [31:0] p, logic [15:0] off, logic [4:0] idx,
                       bit r6, bit slot);
    logic [31:0] expTgt;
    bit exc;
    @(negedge clk);
    inValid   = 1'b1;
    familySel = fam[1:0];
    insnField = {fmt[1:0], idx, off};
    vecData   = v;
    pc        = p;
    rel6Mode  = r6;
    slotFlag  = slot;
    @(negedge clk);
    inValid = 1'b0;
    exc    = r6 && slot;
    expTgt = p + 32'd4 + {{14{off[15]}}, off, 2'b00};
    check("R1", {31'd0, outValid}, 32'd1, "outValid");
    check(req, {31'd0, taken}, {31'd0, refTaken(v, fam, fmt, exc)}, "taken");
    check(exc ? "R7" : "R8", {31'd0, resvExc}, {31'd0, exc}, "resvExc");
    check("R2", target, expTgt, "target");
    check("R11", {27'd0, regIdx}, {27'd0, idx}, "regIdx");
  endtask

  task automatic t_reset();
    rstN = 1'b0; inValid = 1'b0; insnField = '0; familySel = '0;
    vecData = '0; pc = '0; rel6Mode = 1'b0; slotFlag = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R9", {29'd0, outValid, taken, resvExc}, 32'd0, "reset state");
  endtask

  task automatic t_whole();
    issue("R3", 0, 0, '0, 32'h1000, 16'h0010, 5'd3, 0, 0);
    issue("R3", 0, 1, 128'h1 << 127, 32'h1000, 16'h0010, 5'd3, 0, 0);
    issue("R4", 1, 2, 128'h1 << 64, 32'h2000, 16'hFFFF, 5'd7, 0, 0);
    issue("R4", 1, 3, '0, 32'h2000, 16'h8000, 5'd7, 0, 0);
    // format field must not matter for whole-vector families
    for (int f = 0; f < 4; f++) begin
      issue("R10", 0, f, 128'h0000_0100_0000_0000_0000_0000_0000_0000, 32'h40, 16'h1, 5'd1, 0, 0);
      issue("R10", 1, f, 128'h0000_0100_0000_0000_0000_0000_0000_0000, 32'h40, 16'h1, 5'd1, 0, 0);
    end
  endtask

  task automatic t_lanes();
    logic [127:0] allOnes;
    allOnes = '1;
    for (int f = 0; f < 4; f++) begin
      int w;
      w = 8 << f;
      issue("R5", 2, f, allOnes, 32'h100, 16'h4, 5'd2, 0, 0);
      issue("R6", 3, f, allOnes, 32'h100, 16'h4, 5'd2, 0, 0);
      for (int l = 0; l < 128 / w; l++) begin
        logic [127:0] v;
        v = allOnes;
        for (int b = 0; b < w; b++) v[l*w + b] = 1'b0;
        issue("R5", 2, f, v, 32'h200, 16'h8, 5'd9, 0, 0);
        issue("R6", 3, f, v, 32'h200, 16'h8, 5'd9, 0, 0);
      end
      // lanes holding only their top bit or only bit 0
      issue("R6", 3, f, {128/8{8'h01}}, 32'h300, 16'h0, 5'd4, 0, 0);
      issue("R5", 2, f, {2{64'h8000_0000_0000_0000}}, 32'h300, 16'h0, 5'd4, 0, 0);
    end
  endtask

  task automatic t_exc();
    for (int fam = 0; fam < 4; fam++) begin
      logic [127:0] v;
      v = (fam == 1 || fam == 3) ? '1 : '0;
      issue("R7", fam, 0, v, 32'hFFFF_FFF0, 16'h0004, 5'd31, 1, 1);
      issue("R8", fam, 0, v, 32'hFFFF_FFF0, 16'h0004, 5'd31, 1, 0);
      issue("R8", fam, 0, v, 32'hFFFF_FFF0, 16'h0004, 5'd31, 0, 1);
    end
  endtask

  task automatic t_random();
    for (int n = 0; n < 300; n++) begin
      logic [127:0] v;
      int f;
      v = {$urandom, $urandom, $urandom, $urandom};
      f = $urandom_range(0, 3);
      if (n % 3 == 0) v[($urandom_range(0, 15))*8 +: 8] = 8'h00;
      issue($sformatf("R%0d", 3 + (n % 4)), n % 4, f, v, $urandom,
            16'($urandom), 5'($urandom), 1'($urandom), 1'($urandom));
    end
  endtask

  task automatic t_idle();
    @(negedge clk);
    check("R1", {31'd0, outValid}, 32'd0, "outValid after idle");
  endtask

  initial begin
    t_reset();
    t_whole();
    t_lanes();
    t_exc();
    t_random();
    t_idle();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule